// File: doc/BRIEF.md
# EEPROM Status and Write-Protect Unit

This block sits beside the command decoder of a serial EEPROM. It holds the device status byte, decides whether a given array address or the status register itself may be written, and runs the self-timed internal write cycle. The command decoder sends single-cycle strobes: latch-enable, latch-disable, status-write commit and array-write commit. It also supplies the current array address and the byte that came with a status write. The block returns the status byte for the status-read command, two permission flags and a busy indication.

Block protection always covers the top of the array. Two status bits choose whether nothing, the top quarter, the top half or the whole array is locked. A protect-enable bit, together with the external write-protect pin, can also lock the status register itself. The internal write cycle takes a fixed number of clock cycles, set by a parameter. Shorter values are meant for simulation. When a cycle ends, the write-enable latch drops by itself.

Top module: `eeprom_status_guard`

## Requirements
- R1: After reset the status byte reads 0x20 and busy_o, addr_wr_ok_o and sr_wr_ok_o are all 0.
- R2: Status byte layout: bit 7 is the protect-enable bit, bit 6 reads 0, bit 5 reads 1, bit 4 reads 0, bits 3:2 are the block-protect code, bit 1 is the write-enable latch and bit 0 is busy (1 = cycle in progress).
- R3: When idle, wren_i sets the write-enable latch and wrdi_i clears it. If both arrive in the same cycle, wrdi_i wins. While busy, both strobes are ignored.
- R4: Block-protect code 00 locks nothing, 01 locks addresses 0x600–0x7FF, 10 locks 0x400–0x7FF, and 11 locks 0x000–0x7FF. These are the top quarter, top half and whole of an 11-bit address space.
- R5: addr_wr_ok_o is 1 only when the write-enable latch is 1 and addr_i lies outside the locked range.
- R6: sr_wr_ok_o is 1 only when the write-enable latch is 1 and either the protect-enable bit is 0 or wp_i is high.
- R7: A status-write commit made while idle with sr_wr_ok_o high loads status bits 7, 3 and 2 from sr_data_i[7], [3] and [2] at the next edge and starts the write cycle. It takes precedence over an array-write commit in the same cycle.
- R8: An array-write commit made while idle with addr_wr_ok_o high starts the write cycle. Once started, busy reads 1 for exactly CYCLE_CLKS clock cycles.
- R9: The write-enable latch is cleared on the edge at which the write cycle ends.
- R10: A commit that is not permitted, or that arrives while busy, leaves the status bits and the latch unchanged and neither starts nor extends the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wren_i | input | 1 | Set write-enable latch strobe |
| wrdi_i | input | 1 | Clear write-enable latch strobe |
| wrsr_i | input | 1 | Status-register write commit strobe |
| wr_commit_i | input | 1 | Array write commit strobe |
| addr_i | input | ADDR_W | Array address of the pending write |
| sr_data_i | input | 8 | Byte supplied with a status write |
| wp_i | input | 1 | Write-protect pin, high = not asserted |
| status_o | output | 8 | Status byte for status read |
| addr_wr_ok_o | output | 1 | addr_i may be written |
| sr_wr_ok_o | output | 1 | Status register may be written |
| busy_o | output | 1 | Internal write cycle in progress |

## Verification
Assertions check on every cycle that a permitted-address flag never appears without the write-enable latch, that a refused status write leaves the protect bits stable, that busy falls only together with a cleared latch, and that a commit arriving during busy does not reload the cycle counter. The exact protection boundaries for every block-protect code, the cycle length measured in clocks, the field positions of the status byte, and the pin-versus-protect-enable interplay can only be shown by the bench's scenarios.

// File: rtl/eeprom_sr_pkg.sv
package eeprom_sr_pkg;

  localparam int unsigned SR_W = 8;

  typedef enum logic [1:0] {
    BP_NONE = 2'b00,
    BP_QTR  = 2'b01,
    BP_HALF = 2'b10,
    BP_ALL  = 2'b11
  } bp_e;

  typedef struct packed {
    logic wpen;
    bp_e  bp;
    logic wel;
  } sr_state_t;

  function automatic logic [SR_W-1:0] pack_status(sr_state_t s, logic busy);
    return {s.wpen, 1'b0, 1'b1, 1'b0, s.bp, s.wel, busy};
  endfunction

endpackage

// File: rtl/esr_block_guard.sv
module esr_block_guard
  import eeprom_sr_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  bp_e               bp_i,
  output logic              locked_o
);

  localparam int unsigned MSB = ADDR_W - 1;

  logic [1:0] top2;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top2 = addr_i[MSB -: 2];
    end else begin : g_narrow
      assign top2 = {addr_i[0], addr_i[0]};
    end
  endgenerate

  always_comb begin
    unique case (bp_i)
      BP_NONE: locked_o = 1'b0;
      BP_QTR:  locked_o = (top2 == 2'b11);
      BP_HALF: locked_o = top2[1];
      default: locked_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/esr_cycle_timer.sv
module esr_cycle_timer #(
  parameter int unsigned CYCLE_CLKS = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned CNT_W = $clog2(CYCLE_CLKS + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLE_CLKS);

  logic [CNT_W-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (start_i) begin
      cnt_q <= LOAD;
    end
  end

  p_cnt_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LOAD);

  p_no_reload_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/esr_status_regs.sv
module esr_status_regs
  import eeprom_sr_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wren_i,
  input  logic      wrdi_i,
  input  logic      busy_i,
  input  logic      done_i,
  input  logic      sr_load_i,
  input  logic      wrsr_i,
  input  logic      sr_ok_i,
  input  logic      wpen_d_i,
  input  bp_e       bp_d_i,
  output sr_state_t sr_o
);

  sr_state_t sr_q;

  assign sr_o = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '{wpen: 1'b0, bp: BP_NONE, wel: 1'b0};
    end else begin
      if (sr_load_i) begin
        sr_q.wpen <= wpen_d_i;
        sr_q.bp   <= bp_d_i;
      end
      if (done_i) begin
        sr_q.wel <= 1'b0;
      end else if (!busy_i) begin
        if (wrdi_i)      sr_q.wel <= 1'b0;
        else if (wren_i) sr_q.wel <= 1'b1;
      end
    end
  end

  p_locked_sr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrsr_i && !sr_ok_i) |=> ($stable(sr_q.wpen) && $stable(sr_q.bp)));

endmodule

// File: rtl/eeprom_status_guard.sv
module eeprom_status_guard
  import eeprom_sr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned CYCLE_CLKS = 50000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic              wr_commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              wp_i,
  output logic [7:0]        status_o,
  output logic              addr_wr_ok_o,
  output logic              sr_wr_ok_o,
  output logic              busy_o
);

  sr_state_t sr;
  logic      locked, busy, done;
  logic      sr_go, arr_go;
  logic      unused_sr_bits;

  assign unused_sr_bits = ^{sr_data_i[6:4], sr_data_i[1:0]};

  esr_block_guard #(.ADDR_W(ADDR_W)) u_guard (
    .addr_i   (addr_i),
    .bp_i     (sr.bp),
    .locked_o (locked)
  );

  assign addr_wr_ok_o = sr.wel & ~locked;
  assign sr_wr_ok_o   = sr.wel & (~sr.wpen | wp_i);

  // status write wins over a same-cycle array commit
  assign sr_go  = wrsr_i & sr_wr_ok_o & ~busy;
  assign arr_go = wr_commit_i & ~wrsr_i & addr_wr_ok_o & ~busy;

  esr_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sr_go | arr_go),
    .busy_o  (busy),
    .done_o  (done)
  );

  esr_status_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wren_i    (wren_i),
    .wrdi_i    (wrdi_i),
    .busy_i    (busy),
    .done_i    (done),
    .sr_load_i (sr_go),
    .wrsr_i    (wrsr_i),
    .sr_ok_i   (sr_wr_ok_o),
    .wpen_d_i  (sr_data_i[7]),
    .bp_d_i    (bp_e'(sr_data_i[3:2])),
    .sr_o      (sr)
  );

  assign busy_o   = busy;
  assign status_o = pack_status(sr, busy);

  p_ok_needs_wel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_wr_ok_o |-> status_o[1]);

  p_wel_clr_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !status_o[1]);

  p_fixed_bits_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b010);

endmodule

// File: tb/eeprom_status_guard_tb.sv
module eeprom_status_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int CYC        = 16;
  localparam int AW         = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wren = 0, wrdi = 0, wrsr = 0, commit = 0, wp = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    sr_data = '0;
  logic [7:0]    status;
  logic          addr_ok, sr_ok, busy;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eeprom_status_guard #(.ADDR_W(AW), .CYCLE_CLKS(CYC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
    .wr_commit_i(commit), .addr_i(addr), .sr_data_i(sr_data), .wp_i(wp),
    .status_o(status), .addr_wr_ok_o(addr_ok), .sr_wr_ok_o(sr_ok), .busy_o(busy)
  );

  // {bp[1:0], addr[10:0], expected addr_ok}
  localparam logic [13:0] VEC [10] = '{
    {2'b00, 11'h000, 1'b1}, {2'b00, 11'h7FF, 1'b1},
    {2'b01, 11'h5FF, 1'b1}, {2'b01, 11'h600, 1'b0}, {2'b01, 11'h7FF, 1'b0},
    {2'b10, 11'h3FF, 1'b1}, {2'b10, 11'h400, 1'b0},
    {2'b11, 11'h000, 1'b0}, {2'b11, 11'h3FF, 1'b0}, {2'b11, 11'h7FF, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse_wren();
    wren = 1; tick(); wren = 0;
  endtask
  task automatic pulse_wrdi();
    wrdi = 1; tick(); wrdi = 0;
  endtask
  task automatic pulse_wrsr(logic [7:0] d);
    sr_data = d; wrsr = 1; tick(); wrsr = 0;
  endtask
  task automatic pulse_commit(logic [AW-1:0] a);
    addr = a; commit = 1; tick(); commit = 0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      tick();
    end
  endtask

  task automatic set_bp(logic [1:0] bp);
    int n;
    pulse_wren();
    pulse_wrsr({4'b0000, bp, 2'b00});
    wait_idle(n);
    pulse_wren();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [1:0] cur_bp;
    tick();
    tick();
    // R1 reset state
    check("R1 status", status, 8'h20);
    check("R1 busy", busy, 0);
    check("R1 addr_ok", addr_ok, 0);
    check("R1 sr_ok", sr_ok, 0);
    rst_n = 1;
    tick();

    // R4/R5 protection table
    cur_bp = 2'b00;
    pulse_wren();
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][13:12] != cur_bp) begin
        cur_bp = VEC[i][13:12];
        set_bp(cur_bp);
      end
      addr = VEC[i][11:1];
      #1;
      check($sformatf("R4 bp=%0d addr=%0h", cur_bp, addr), addr_ok, VEC[i][0]);
    end

    set_bp(2'b00);
    // R5 latch gates permission
    pulse_wrdi();
    addr = 11'h010;
    #1;
    check("R5 no latch", addr_ok, 0);
    // R3 both strobes: clear wins
    pulse_wren();
    wren = 1; wrdi = 1; tick(); wren = 0; wrdi = 0;
    check("R3 wrdi priority", status, 8'h20);

    // R10 refused status write with latch clear
    pulse_wrsr(8'hFF);
    check("R10 refused sr status", status, 8'h20);
    check("R10 refused sr busy", busy, 0);

    // R7/R2 accepted status write loads bits 7,3,2 only
    pulse_wren();
    pulse_wrsr(8'hFF);
    check("R7 R2 status after wrsr", status, 8'hAF);
    wait_idle(n);
    check("R8 cycle length", n, CYC);
    check("R9 latch cleared", status, 8'hAC);

    // R6 pin vs protect-enable
    pulse_wren();
    wp = 0;
    #1;
    check("R6 wp low locked", sr_ok, 0);
    pulse_wrsr(8'h00);
    check("R10 locked sr unchanged", status, 8'hAE);
    wp = 1;
    #1;
    check("R6 wp high unlocked", sr_ok, 1);
    pulse_wrsr(8'h00);
    check("R7 sr cleared", status, 8'h23);
    wait_idle(n);
    check("R9 after sr write", status, 8'h20);

    // R8/R3/R10 array write with strobes during busy
    pulse_wren();
    pulse_commit(11'h123);
    check("R8 busy starts", status, 8'h23);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 2) wrdi = 1;
      if (n == 3) begin wrdi = 0; commit = 1; end
      if (n == 4) begin
        commit = 0;
        check("R3 wrdi ignored busy", status[1], 1);
      end
      tick();
    end
    check("R10 no extension", n, CYC);
    check("R9 after array write", status, 8'h20);

    // R10 commit to locked address
    set_bp(2'b01);
    pulse_commit(11'h700);
    check("R10 locked commit busy", busy, 0);
    check("R10 locked commit status", status, 8'h26);

    // R10 commit with latch clear
    pulse_wrdi();
    pulse_commit(11'h010);
    check("R10 no latch commit", busy, 0);

    // R7 status write wins over same-cycle array commit
    pulse_wren();
    addr = 11'h700; sr_data = 8'h00; wrsr = 1; commit = 1; tick();
    wrsr = 0; commit = 0;
    check("R7 precedence", status, 8'h23);
    wait_idle(n);
    check("R8 precedence length", n, CYC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule